// File: doc/BRIEF.md
# Four-Lane Element-Wise Add Unit

This unit is the arithmetic back end of a lane-parallel vector and matrix engine. Operands live in per-lane register slices. Each of the four lanes holds eight registers of sixteen 16-bit elements.

The two operand shapes are striped across the lanes differently:
- **Vector:** element k sits in lane k mod 4, at position k div 4.
- **Matrix:** column j sits in lane j, with its rows stacked by row index.

Because an element-wise add keeps every result in the lane and position of its operands, the same datapath serves both shapes.

Before any operation, software must load a 32-bit lane-control word. This word decides how many lanes take part and how many elements each lane sweeps. After that, a start pulse names the operation kind, the destination register and two source registers. All active lanes then step through element positions 0 to N-1 together, one position per cycle. A side port loads the register slices and reads them back.

Top module: `lane_exec_unit`

## Requirements
- R1: While reset is held and after it is released, busy, done and err are low, and no lane configuration is in force.
- R2: A control word takes effect only if bits [31:26] equal 6'h1C and bits [25:20] equal 6'h05. Bits [9:5] give the active lane count and bits [4:0] give the elements per lane. Any other word changes nothing.
- R3: A lane count of 0 or above 4 becomes 4. An element count of 0 or above 16 becomes 16.
- R4: A start with no accepted configuration sets err for one cycle, starting the cycle after the start. busy stays low and no register changes.
- R5: After an accepted start, busy is high for exactly N cycles, starting the cycle after the start. done is high for the single cycle after busy falls.
- R6: For each active lane and each position e below N, dst[e] becomes srcA[e] + srcB[e] modulo 2^16.
- R7: Positions at or above N in the destination keep their contents.
- R8: Lanes at or above the active count keep their destination contents.
- R9: Vector element k is read at lane k mod 4, position k div 4. Matrix element (i, j) is read at lane j, position i. Both add kinds (op_kind 0 = vector, 1 = matrix) place each result at the location of its operands.
- R10: While busy, op_start and cfg_valid are ignored. The running operation and the configuration in force are unchanged.
- R11: An access-port write sets the element at (acc_lane, acc_reg, acc_idx). acc_rdata shows that element in the same cycle. Writes while busy are ignored.
- R12: The destination may equal a source register. Each position then holds the sum of its own old operand values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Presents a lane-control word |
| cfg_word | input | 32 | Lane-control word |
| op_start | input | 1 | Start pulse for an add |
| op_kind | input | 1 | 0 vector add, 1 matrix add |
| op_dst | input | 3 | Destination register |
| op_src_a | input | 3 | First source register |
| op_src_b | input | 3 | Second source register |
| busy | output | 1 | Operation running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle start-rejected pulse |
| acc_wr | input | 1 | Access-port write strobe |
| acc_lane | input | 2 | Access lane |
| acc_reg | input | 3 | Access register |
| acc_idx | input | 4 | Access element position |
| acc_wdata | input | 16 | Access write data |
| acc_rdata | output | 16 | Access read data (combinational) |

## Verification
The configuration and the access port act at the clock edge that samples them. A readback therefore settles in the same low phase in which its address is driven.

A start sampled at edge t gives two possible outcomes:
- **Rejected:** err is high only in the cycle after t.
- **Accepted:** busy is high in the cycle after t and for N cycles in total, and done is high in the next cycle.

The bench drives on falling edges and counts busy cycles at falling edges. It checks done and err in the exact falling-edge slot where each is due, and checks done is low one cycle later. Register contents are compared only after done, through the access port, against a model built from R6 to R9.

// File: rtl/lane_exec_pkg.sv
// Shared constants and types for the lane-parallel add unit.
// Assumes the lane-control word is 32 bits with fixed field positions.
package lane_exec_pkg;
    localparam int LANES_DEF  = 4;
    localparam int REGS_DEF   = 8;
    localparam int ELEMS_DEF  = 16;
    localparam int DATA_W_DEF = 16;
    localparam int CFG_W      = 32;

    localparam logic [5:0] CLASS_MATRIX = 6'h1C;
    localparam logic [5:0] OPC_LANECTL  = 6'h05;

    typedef enum logic {
        KIND_ADD_VV = 1'b0,
        KIND_ADD_MM = 1'b1
    } op_kind_e;

    typedef struct packed {
        logic [5:0] cls;
        logic [5:0] opc;
        logic [9:0] strips;
        logic [4:0] width;
        logic [4:0] dim;
    } lanectl_word_t;
endpackage

// File: rtl/lane_cfg_decode.sv
// Lane-control decoder: checks the class and opcode fields, clamps the lane
// and element counts, and holds them until the next accepted word.
// Assumes hold is high while an operation runs; words seen then are dropped.
module lane_cfg_decode
    import lane_exec_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int ELEMS  = ELEMS_DEF,
    parameter int LCNT_W = $clog2(LANES + 1),
    parameter int CNT_W  = $clog2(ELEMS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              hold,
    output logic              cfg_ok,
    output logic [LCNT_W-1:0] act_lanes,
    output logic [CNT_W-1:0]  elems
);
    lanectl_word_t    word;
    logic             accept;
    logic [LCNT_W-1:0] lanes_clamped;
    logic [CNT_W-1:0]  elems_clamped;
    logic [9:0]        unused_strips;

    assign word          = lanectl_word_t'(cfg_word);
    assign unused_strips = word.strips;

    // Accept only a well-formed lane-control word while idle.
    assign accept = cfg_valid && !hold &&
                    (word.cls == CLASS_MATRIX) && (word.opc == OPC_LANECTL);

    // Clamp out-of-range counts to the full size.
    always_comb begin
        if (word.width == 5'd0 || int'(word.width) > LANES)
            lanes_clamped = LCNT_W'(LANES);
        else
            lanes_clamped = LCNT_W'(word.width);
        if (word.dim == 5'd0 || int'(word.dim) > ELEMS)
            elems_clamped = CNT_W'(ELEMS);
        else
            elems_clamped = CNT_W'(word.dim);
    end

    // Hold the configuration in force.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_ok    <= 1'b0;
            act_lanes <= '0;
            elems     <= '0;
        end else if (accept) begin
            cfg_ok    <= 1'b1;
            act_lanes <= lanes_clamped;
            elems     <= elems_clamped;
        end
    end
endmodule

// File: rtl/lane_seq.sv
// Operation sequencer: accepts a start when configured, steps the shared
// element position once per cycle, and pulses done or err.
// Assumes elems is nonzero whenever cfg_ok is high and stays fixed while busy.
module lane_seq #(
    parameter int REGS  = 8,
    parameter int ELEMS = 16,
    parameter int CNT_W = $clog2(ELEMS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_start,
    input  logic [$clog2(REGS)-1:0]  op_dst,
    input  logic [$clog2(REGS)-1:0]  op_src_a,
    input  logic [$clog2(REGS)-1:0]  op_src_b,
    input  logic                     cfg_ok,
    input  logic [CNT_W-1:0]         elems,
    output logic                     busy,
    output logic                     done,
    output logic                     err,
    output logic [$clog2(ELEMS)-1:0] step_idx,
    output logic [$clog2(REGS)-1:0]  cur_dst,
    output logic [$clog2(REGS)-1:0]  cur_a,
    output logic [$clog2(REGS)-1:0]  cur_b
);
    logic last_step;

    // Final position reached when the next position would equal elems.
    assign last_step = (CNT_W'(step_idx) + CNT_W'(1)) == elems;

    // Run state, position counter and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            step_idx <= '0;
            cur_dst  <= '0;
            cur_a    <= '0;
            cur_b    <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (busy) begin
                if (last_step) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    step_idx <= step_idx + 1'b1;
                end
            end else if (op_start) begin
                if (cfg_ok) begin
                    busy     <= 1'b1;
                    step_idx <= '0;
                    cur_dst  <= op_dst;
                    cur_a    <= op_src_a;
                    cur_b    <= op_src_b;
                end else begin
                    err <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lane_slice.sv
// One lane's register slice with its adder: two operand read ports, one
// access read port and one write port.
// Assumes REGS and ELEMS are powers of two; the add step has priority.
module lane_slice #(
    parameter int REGS   = 8,
    parameter int ELEMS  = 16,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     exec_we,
    input  logic [$clog2(REGS)-1:0]  exec_dst,
    input  logic [$clog2(REGS)-1:0]  exec_a,
    input  logic [$clog2(REGS)-1:0]  exec_b,
    input  logic [$clog2(ELEMS)-1:0] exec_idx,
    input  logic                     acc_we,
    input  logic [$clog2(REGS)-1:0]  acc_reg,
    input  logic [$clog2(ELEMS)-1:0] acc_idx,
    input  logic [DATA_W-1:0]        acc_wdata,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int REG_W  = $clog2(REGS);
    localparam int IDX_W  = $clog2(ELEMS);
    localparam int ADDR_W = REG_W + IDX_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] sum;

    // Fetch both operands of the current position and add them.
    always_comb begin
        opnd_a = store[{exec_a, exec_idx}];
        opnd_b = store[{exec_b, exec_idx}];
        sum    = opnd_a + opnd_b;
    end

    // Readback of the addressed element.
    assign rd_data = store[{acc_reg, acc_idx}];

    // Write either the sum or the access-port data.
    always_ff @(posedge clk) begin
        if (exec_we)
            store[{exec_dst, exec_idx}] <= sum;
        else if (acc_we)
            store[{acc_reg, acc_idx}] <= acc_wdata;
    end
endmodule

// File: rtl/lane_exec_unit.sv
// Top of the lane-parallel add unit: decoder, sequencer and one slice per
// lane, plus the access-port steering.
// Assumes vector and matrix adds share placement, so op_kind selects no path.
module lane_exec_unit
    import lane_exec_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int REGS   = REGS_DEF,
    parameter int ELEMS  = ELEMS_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_valid,
    input  logic [CFG_W-1:0]          cfg_word,
    input  logic                      op_start,
    input  logic                      op_kind,
    input  logic [$clog2(REGS)-1:0]   op_dst,
    input  logic [$clog2(REGS)-1:0]   op_src_a,
    input  logic [$clog2(REGS)-1:0]   op_src_b,
    output logic                      busy,
    output logic                      done,
    output logic                      err,
    input  logic                      acc_wr,
    input  logic [$clog2(LANES)-1:0]  acc_lane,
    input  logic [$clog2(REGS)-1:0]   acc_reg,
    input  logic [$clog2(ELEMS)-1:0]  acc_idx,
    input  logic [DATA_W-1:0]         acc_wdata,
    output logic [DATA_W-1:0]         acc_rdata
);
    localparam int LANE_W = $clog2(LANES);
    localparam int REG_W  = $clog2(REGS);
    localparam int IDX_W  = $clog2(ELEMS);
    localparam int LCNT_W = $clog2(LANES + 1);
    localparam int CNT_W  = $clog2(ELEMS + 1);

    logic              cfg_ok;
    logic [LCNT_W-1:0] act_lanes;
    logic [CNT_W-1:0]  cfg_elems;
    logic [IDX_W-1:0]  step_idx;
    logic [REG_W-1:0]  cur_dst;
    logic [REG_W-1:0]  cur_a;
    logic [REG_W-1:0]  cur_b;
    logic [DATA_W-1:0] lane_rd [LANES];
    logic              unused_kind;

    assign unused_kind = op_kind;

    u_cfg_dummy_guard: assert final (LANES >= 1);

    lane_cfg_decode #(
        .LANES (LANES),
        .ELEMS (ELEMS),
        .LCNT_W(LCNT_W),
        .CNT_W (CNT_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_valid(cfg_valid),
        .cfg_word (cfg_word),
        .hold     (busy),
        .cfg_ok   (cfg_ok),
        .act_lanes(act_lanes),
        .elems    (cfg_elems)
    );

    lane_seq #(
        .REGS (REGS),
        .ELEMS(ELEMS),
        .CNT_W(CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_start(op_start),
        .op_dst  (op_dst),
        .op_src_a(op_src_a),
        .op_src_b(op_src_b),
        .cfg_ok  (cfg_ok),
        .elems   (cfg_elems),
        .busy    (busy),
        .done    (done),
        .err     (err),
        .step_idx(step_idx),
        .cur_dst (cur_dst),
        .cur_a   (cur_a),
        .cur_b   (cur_b)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic lane_on;
        logic lane_acc_we;

        // Lane takes part when its number is below the active count.
        assign lane_on     = busy && (LCNT_W'(l) < act_lanes);
        // Access writes reach this lane only while idle.
        assign lane_acc_we = acc_wr && !busy && (acc_lane == LANE_W'(l));

        lane_slice #(
            .REGS  (REGS),
            .ELEMS (ELEMS),
            .DATA_W(DATA_W)
        ) u_slice (
            .clk      (clk),
            .exec_we  (lane_on),
            .exec_dst (cur_dst),
            .exec_a   (cur_a),
            .exec_b   (cur_b),
            .exec_idx (step_idx),
            .acc_we   (lane_acc_we),
            .acc_reg  (acc_reg),
            .acc_idx  (acc_idx),
            .acc_wdata(acc_wdata),
            .rd_data  (lane_rd[l])
        );
    end

    // Readback mux over lanes.
    assign acc_rdata = lane_rd[acc_lane];
endmodule

// File: rtl/lane_exec_checker.sv
// Protocol checker for lane_exec_unit: reset state, start outcomes and the
// busy window length, bound onto the top module.
// Assumes cfg_elems is the element count held by the decoder.
module lane_exec_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_start,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [CNT_W-1:0] cfg_elems
);
    logic [CNT_W:0] run_len;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else if (busy)
            run_len <= run_len + 1'b1;
        else
            run_len <= '0;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !err));

    a_r4_err_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(op_start) && !busy));

    a_r5_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(op_start));

    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == {1'b0, cfg_elems}));
endmodule

bind lane_exec_unit lane_exec_checker #(.CNT_W($clog2(ELEMS + 1))) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .cfg_elems(cfg_elems)
);

// File: tb/lane_exec_unit_test.sv
// Scoreboard bench for lane_exec_unit: driver tasks push expected register
// contents into a queue; the monitor pops them and compares via readback.
module lane_exec_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        op_start = 1'b0;
    logic        op_kind = 1'b0;
    logic [2:0]  op_dst = '0, op_src_a = '0, op_src_b = '0;
    logic        busy, done, err;
    logic        acc_wr = 1'b0;
    logic [1:0]  acc_lane = '0;
    logic [2:0]  acc_reg = '0;
    logic [3:0]  acc_idx = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;

    typedef struct {
        int          lane;
        int          rg;
        int          idx;
        logic [15:0] val;
        string       req;
    } exp_item_t;

    exp_item_t   sb_q[$];
    logic [15:0] model [4][8][16];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    lane_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
        .op_start(op_start), .op_kind(op_kind), .op_dst(op_dst),
        .op_src_a(op_src_a), .op_src_b(op_src_b), .busy(busy), .done(done),
        .err(err), .acc_wr(acc_wr), .acc_lane(acc_lane), .acc_reg(acc_reg),
        .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // All tasks enter and leave just after a falling edge.
    task automatic poke(input int l, input int r, input int i, input logic [15:0] v);
        acc_lane = 2'(l); acc_reg = 3'(r); acc_idx = 4'(i); acc_wdata = v; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0;
        model[l][r][i] = v;
    endtask

    task automatic peek(input int l, input int r, input int i, output logic [15:0] v);
        acc_lane = 2'(l); acc_reg = 3'(r); acc_idx = 4'(i);
        #1 v = acc_rdata;
    endtask

    task automatic configure(input logic [5:0] cls, input logic [5:0] opc,
                             input logic [4:0] width, input logic [4:0] dim);
        cfg_word = {cls, opc, 10'd3, width, dim};
        cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    // Driver side: queue expected contents of one register in every lane.
    task automatic expect_reg(input int r, input int lanes_on, input int n, input string base);
        for (int l = 0; l < 4; l++) begin
            for (int i = 0; i < 16; i++) begin
                exp_item_t it;
                it.lane = l; it.rg = r; it.idx = i; it.val = model[l][r][i];
                if (l >= lanes_on)  it.req = "R8";
                else if (i >= n)    it.req = "R7";
                else                it.req = base;
                sb_q.push_back(it);
            end
        end
    endtask

    // Monitor side: pop and compare against readback.
    task automatic monitor_drain();
        logic [15:0] v;
        while (sb_q.size() > 0) begin
            exp_item_t it = sb_q.pop_front();
            peek(it.lane, it.rg, it.idx, v);
            check(v == it.val, it.req, $sformatf("lane%0d reg%0d idx%0d", it.lane, it.rg, it.idx),
                  int'(v), int'(it.val));
        end
        @(negedge clk);
    endtask

    task automatic start_expect_err(input string req, input int r);
        op_dst = 3'(r); op_src_a = 3'd1; op_src_b = 3'd2; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        check(err == 1'b1, req, "err after rejected start", int'(err), 1);
        check(busy == 1'b0, req, "busy after rejected start", int'(busy), 0);
        @(negedge clk);
        check(err == 1'b0, req, "err one cycle only", int'(err), 0);
        expect_reg(r, 0, 0, req);
        monitor_drain();
    endtask

    task automatic run_op(input logic kind, input int d, input int a, input int b,
                          input int lanes_on, input int n, input string req,
                          input bit disturb);
        int cnt;
        for (int l = 0; l < lanes_on; l++)
            for (int i = 0; i < n; i++)
                model[l][d][i] = model[l][a][i] + model[l][b][i];
        op_kind = kind; op_dst = 3'(d); op_src_a = 3'(a); op_src_b = 3'(b);
        op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        check(busy == 1'b1, req, "busy in cycle after start", int'(busy), 1);
        cnt = 0;
        while (busy && cnt < 40) begin
            cnt++;
            if (disturb && cnt == 1) begin
                op_dst = 3'd0; op_start = 1'b1;
                cfg_word = {6'h1C, 6'h05, 10'd0, 5'd1, 5'd1}; cfg_valid = 1'b1;
                acc_lane = 2'd0; acc_reg = 3'd2; acc_idx = 4'd9;
                acc_wdata = 16'hDEAD; acc_wr = 1'b1;
            end else begin
                op_start = 1'b0; cfg_valid = 1'b0; acc_wr = 1'b0;
            end
            @(negedge clk);
        end
        op_start = 1'b0; cfg_valid = 1'b0; acc_wr = 1'b0;
        check(cnt == n, req, "busy cycle count", cnt, n);
        check(done == 1'b1, req, "done after busy", int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, req, "done single cycle", int'(done), 0);
        expect_reg(d, lanes_on, n, "R6");
        monitor_drain();
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && err == 0, "R1", "outputs in reset",
              int'({busy, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && err == 0, "R1", "outputs after reset",
              int'({busy, done, err}), 0);

        // Preload every element (R11).
        for (int l = 0; l < 4; l++)
            for (int r = 0; r < 8; r++)
                for (int i = 0; i < 16; i++)
                    poke(l, r, i, 16'(16'hE000 + l * 4099 + r * 613 + i * 97));
        poke(0, 1, 0, 16'hFFFF);
        poke(0, 2, 0, 16'h0002);
        poke(3, 7, 15, 16'h5A5A);
        peek(3, 7, 15, v);
        check(v == 16'h5A5A, "R11", "readback after write", int'(v), 16'h5A5A);
        @(negedge clk);

        // R1 and R4: no configuration yet.
        start_expect_err("R4", 3);
        // R2: bad class, then bad opcode, are ignored.
        configure(6'h1D, 6'h05, 5'd4, 5'd16);
        start_expect_err("R2", 3);
        configure(6'h1C, 6'h06, 5'd4, 5'd16);
        start_expect_err("R2", 3);

        // Full vector add with wrap (R6, R9).
        configure(6'h1C, 6'h05, 5'd4, 5'd16);
        run_op(1'b0, 3, 1, 2, 4, 16, "R5", 1'b0);
        peek(0, 3, 0, v);
        check(v == 16'h0001, "R6", "wrapping sum", int'(v), 1);
        for (int k = 0; k < 64; k++) begin
            peek(k % 4, 3, k / 4, v);
            check(v == 16'(model[k % 4][1][k / 4] + model[k % 4][2][k / 4]), "R9",
                  $sformatf("vector element %0d", k), int'(v),
                  int'(16'(model[k % 4][1][k / 4] + model[k % 4][2][k / 4])));
        end
        @(negedge clk);

        // Two lanes, five elements, matrix add (R7, R8, R9).
        configure(6'h1C, 6'h05, 5'd2, 5'd5);
        run_op(1'b1, 4, 5, 6, 2, 5, "R5", 1'b0);
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 2; j++) begin
                peek(j, 4, i, v);
                check(v == 16'(model[j][5][i] + model[j][6][i]), "R9",
                      $sformatf("matrix element %0d,%0d", i, j), int'(v),
                      int'(16'(model[j][5][i] + model[j][6][i])));
            end
        @(negedge clk);

        // Clamping (R3).
        configure(6'h1C, 6'h05, 5'd0, 5'd0);
        run_op(1'b0, 5, 3, 4, 4, 16, "R3", 1'b0);
        configure(6'h1C, 6'h05, 5'd7, 5'd20);
        // In-place matrix add under clamp (R12).
        run_op(1'b1, 6, 6, 1, 4, 16, "R12", 1'b0);

        // Disturbance while busy (R10, R11).
        configure(6'h1C, 6'h05, 5'd3, 5'd4);
        run_op(1'b0, 7, 0, 1, 3, 4, "R10", 1'b1);
        peek(0, 2, 9, v);
        check(v == model[0][2][9], "R11", "write while busy ignored", int'(v), int'(model[0][2][9]));
        expect_reg(0, 0, 0, "R10");
        monitor_drain();
        run_op(1'b0, 0, 2, 3, 3, 4, "R10", 1'b0);

        summary();
    end
endmodule